// File: doc/BRIEF.md
# Frame-Offset Video Timing Generator

This block produces the line sync, frame sync, data-enable and pixel-request signals for a display link that runs in continuous video mode. Software loads a small register bank through a write port. The block then counts pixel clocks from two counters. One counter spans the whole frame. The other gives the column within the current line. Every vertical boundary is written as an absolute pixel-clock offset within the frame, not as a line number. This lets a line-level skew be folded into the start and end points of the visible area.

Inside the display window, the block passes the incoming pixel through when the position also lies within a second, optional horizontal active window. At other positions inside the display window it outputs a programmable 24-bit border colour. Outside the display window it outputs zero. All timing values are staged. They take effect together on the first pixel of the next frame, so a frame already being scanned keeps its geometry.

Top module: `vtg_timing_gen`

## Requirements
- R1: After reset, the enable bit is clear, every staged value is zero, and hsync, vsync, de, pix_ready and pix_out are all 0.
- R2: hsync is active while the column counter c satisfies skew <= c < skew + pulse. The pulse width is bits 15:0 of address 1 and the skew is bits 15:0 of address 9.
- R3: vsync is active while the frame counter f is below the vsync width in pixel clocks. That width is the full word at address 3.
- R4: On the first enabled cycle both counters read 0. The column counter wraps to 0 after the line length − 1; the line length is bits 31:16 of address 1. Both counters return to 0 after frame position (frame length − 1); the frame length is the word at address 2.
- R5: de is active when f lies in [vertical first, vertical last] and c lies in [horizontal first, horizontal last]. All bounds are inclusive. The vertical bounds are the words at addresses 5 and 6. The horizontal first and last columns are bits 15:0 and 31:16 of address 4.
- R6: pix_out equals pix_in when pix_ready is high. It equals the border colour (bits 23:0 of address 8) inside the display window when pix_ready is low. It is 0 elsewhere.
- R7: pix_ready is high when de's window condition holds and, if bit 31 of address 7 is set, c also lies in [bits 15:0, bits 30:16] of address 7. When bit 31 is clear, only the display window applies.
- R8: While bit 0 of address 0 is clear, both counters are held at 0. hsync, vsync and de then rest at their inactive levels (equal to their invert bits), and pix_ready and pix_out are 0.
- R9: A write to any address from 1 to 10 made while the block runs changes nothing until the cycle after the frame counter reaches frame length − 1. While disabled, staged values become live one cycle after the write.
- R10: Bits 0, 1 and 2 of address 10 invert hsync, vsync and de respectively. pix_ready is never inverted.
- R11: Address 0 bit 0 is the enable and takes effect on the next cycle. Writes to addresses 11 to 15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| pix_in | input | 24 | Pixel value from the fetch path |
| pix_ready | output | 1 | Requests pix_in for the current cycle |
| hsync | output | 1 | Line sync after polarity |
| vsync | output | 1 | Frame sync after polarity |
| de | output | 1 | Display window after polarity |
| pix_out | output | 24 | Pixel, border colour or blank |

## Verification
The assertions check, on every cycle, several properties that must always hold. Both counters stay below their live periods and restart together after a frame wrap. Live timing stays constant between frame boundaries. pix_ready never rises outside the display window and always forwards pix_in. When disabled, no pixel is requested or driven. The exact positions of the sync pulses, the window bounds, the border colour, the polarity inversion and the moment a mid-frame write becomes live can only be shown by the bench scenarios. These compare every cycle against a model built from the requirements, across directed geometry, random geometries and writes made mid-frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    parameter int LINE_W  = 16;
    parameter int FRAME_W = 32;
    parameter int COLOR_W = 24;
    parameter int ADDR_W  = 4;
    parameter int POL_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_RUN    = 4'd0,
        A_LINE   = 4'd1,
        A_FRAME  = 4'd2,
        A_VSW    = 4'd3,
        A_HWIN   = 4'd4,
        A_VFIRST = 4'd5,
        A_VLAST  = 4'd6,
        A_ACT    = 4'd7,
        A_BORDER = 4'd8,
        A_SKEW   = 4'd9,
        A_INV    = 4'd10
    } reg_addr_e;

    typedef struct packed {
        logic [LINE_W-1:0]  line_len;
        logic [LINE_W-1:0]  hs_width;
        logic [LINE_W-1:0]  win_h_first;
        logic [LINE_W-1:0]  win_h_last;
        logic               act_on;
        logic [LINE_W-1:0]  act_h_first;
        logic [LINE_W-2:0]  act_h_last;
        logic [LINE_W-1:0]  skew;
        logic [FRAME_W-1:0] frame_len;
        logic [FRAME_W-1:0] vs_len;
        logic [FRAME_W-1:0] win_v_first;
        logic [FRAME_W-1:0] win_v_last;
        logic [COLOR_W-1:0] border;
        logic [POL_W-1:0]   invert;
    } cfg_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              frame_wrap,
    output logic              run,
    output cfg_t              cfg
);
    typedef struct packed {
        logic en;
        cfg_t stage;
        cfg_t live;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        // staged values become live at the frame boundary or while idle
        if (!regs_q.en || frame_wrap) regs_d.live = regs_q.stage;
        if (wr_en) begin
            case (wr_addr)
                A_RUN:    regs_d.en = wr_data[0];
                A_LINE: begin
                    regs_d.stage.line_len = wr_data[16 +: LINE_W];
                    regs_d.stage.hs_width = wr_data[0 +: LINE_W];
                end
                A_FRAME:  regs_d.stage.frame_len = wr_data[FRAME_W-1:0];
                A_VSW:    regs_d.stage.vs_len    = wr_data[FRAME_W-1:0];
                A_HWIN: begin
                    regs_d.stage.win_h_last  = wr_data[16 +: LINE_W];
                    regs_d.stage.win_h_first = wr_data[0 +: LINE_W];
                end
                A_VFIRST: regs_d.stage.win_v_first = wr_data[FRAME_W-1:0];
                A_VLAST:  regs_d.stage.win_v_last  = wr_data[FRAME_W-1:0];
                A_ACT: begin
                    regs_d.stage.act_on      = wr_data[31];
                    regs_d.stage.act_h_last  = wr_data[16 +: LINE_W-1];
                    regs_d.stage.act_h_first = wr_data[0 +: LINE_W];
                end
                A_BORDER: regs_d.stage.border = wr_data[COLOR_W-1:0];
                A_SKEW:   regs_d.stage.skew   = wr_data[0 +: LINE_W];
                A_INV:    regs_d.stage.invert = wr_data[POL_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign run = regs_q.en;
    assign cfg = regs_q.live;

    // R9
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.en && $past(regs_q.en) && !$past(frame_wrap)) |-> $stable(regs_q.live));
endmodule

// File: rtl/vtg_counters.sv
module vtg_counters
    import vtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [LINE_W-1:0]  line_len,
    input  logic [FRAME_W-1:0] frame_len,
    output logic [LINE_W-1:0]  hpos,
    output logic [FRAME_W-1:0] fpos,
    output logic               frame_wrap
);
    typedef struct packed {
        logic [LINE_W-1:0]  h;
        logic [FRAME_W-1:0] f;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    assign frame_wrap = run && (cnt_q.f == frame_len - FRAME_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run || frame_wrap) begin
            cnt_d = '0;
        end else begin
            cnt_d.f = cnt_q.f + FRAME_W'(1);
            cnt_d.h = (cnt_q.h == line_len - LINE_W'(1)) ? '0 : cnt_q.h + LINE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hpos = cnt_q.h;
    assign fpos = cnt_q.f;

    // R4
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && frame_len != '0) |-> (fpos < frame_len));
    // R4
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && line_len != '0) |-> (hpos < line_len));
    // R4
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (fpos == '0 && hpos == '0));
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
    import vtg_pkg::*;
(
    input  logic               run,
    input  cfg_t               cfg,
    input  logic [LINE_W-1:0]  hpos,
    input  logic [FRAME_W-1:0] fpos,
    input  logic [COLOR_W-1:0] pix_in,
    output logic               hs_raw,
    output logic               vs_raw,
    output logic               in_window,
    output logic               ready,
    output logic [COLOR_W-1:0] pix_out
);
    logic [LINE_W:0] hs_end;
    logic            v_ok, h_ok, act_ok;

    assign hs_end = {1'b0, cfg.skew} + {1'b0, cfg.hs_width};

    always_comb begin
        hs_raw    = run && (hpos >= cfg.skew) && ({1'b0, hpos} < hs_end);
        vs_raw    = run && (fpos < cfg.vs_len);
        v_ok      = run && (fpos >= cfg.win_v_first) && (fpos <= cfg.win_v_last);
        h_ok      = (hpos >= cfg.win_h_first) && (hpos <= cfg.win_h_last);
        act_ok    = !cfg.act_on ||
                    ((hpos >= cfg.act_h_first) && (hpos <= {1'b0, cfg.act_h_last}));
        in_window = v_ok && h_ok;
        ready     = in_window && act_ok;
        if (ready)          pix_out = pix_in;
        else if (in_window) pix_out = cfg.border;
        else                pix_out = '0;
    end
endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
    import vtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [COLOR_W-1:0] pix_in,
    output logic               pix_ready,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [COLOR_W-1:0] pix_out
);
    logic               run, frame_wrap;
    cfg_t               cfg;
    logic [LINE_W-1:0]  hpos;
    logic [FRAME_W-1:0] fpos;
    logic               hs_raw, vs_raw, in_window;

    vtg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_wrap (frame_wrap),
        .run        (run),
        .cfg        (cfg)
    );

    vtg_counters u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .line_len   (cfg.line_len),
        .frame_len  (cfg.frame_len),
        .hpos       (hpos),
        .fpos       (fpos),
        .frame_wrap (frame_wrap)
    );

    vtg_decode u_dec (
        .run       (run),
        .cfg       (cfg),
        .hpos      (hpos),
        .fpos      (fpos),
        .pix_in    (pix_in),
        .hs_raw    (hs_raw),
        .vs_raw    (vs_raw),
        .in_window (in_window),
        .ready     (pix_ready),
        .pix_out   (pix_out)
    );

    assign hsync = hs_raw    ^ cfg.invert[0];
    assign vsync = vs_raw    ^ cfg.invert[1];
    assign de    = in_window ^ cfg.invert[2];

    // R7
    ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> in_window);
    // R6
    ready_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> (pix_out == pix_in));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pix_ready && pix_out == '0 && !in_window));
endmodule

// File: tb/vtg_timing_gen_tb.sv
`timescale 1ns/1ps
module vtg_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic [23:0] pix_in;
    logic        pix_ready, hsync, vsync, de;
    logic [23:0] pix_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] st [0:15];
    logic [31:0] sh [0:15];
    int          mh, mf;
    logic [31:0] cw [1:10];
    bit          e_hs, e_vs, e_de, e_rdy;
    logic [23:0] e_pix;

    always #2 clk = ~clk;

    vtg_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_in(pix_in), .pix_ready(pix_ready),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive, compare against the model, advance the model
    task automatic tick(input bit w, input int a, input logic [31:0] v);
        bit en, wrapm, vd, hd, ha, win;
        int hper, hpw, vper, vpw, hst, hen, vst, ven, ast, aen, skew;
        logic [2:0] pol;
        @(negedge clk);
        wr_en = w; wr_addr = a[3:0]; wr_data = v; pix_in = 24'($urandom);
        #1;
        en   = st[0][0];
        hper = int'(sh[1][31:16]); hpw = int'(sh[1][15:0]);
        vper = int'(sh[2]);        vpw = int'(sh[3]);
        hst  = int'(sh[4][15:0]);  hen = int'(sh[4][31:16]);
        vst  = int'(sh[5]);        ven = int'(sh[6]);
        ast  = int'(sh[7][15:0]);  aen = int'(sh[7][30:16]);
        skew = int'(sh[9][15:0]);  pol = sh[10][2:0];
        e_hs  = en && mh >= skew && mh < skew + hpw;
        e_vs  = en && mf < vpw;
        vd    = en && mf >= vst && mf <= ven;
        hd    = mh >= hst && mh <= hen;
        ha    = !sh[7][31] || (mh >= ast && mh <= aen);
        win   = vd && hd;
        e_rdy = win && ha;
        e_de  = win;
        e_pix = e_rdy ? pix_in : (win ? sh[8][23:0] : 24'h0);
        chk(hsync == (e_hs ^ pol[0]), "R2 R10", "hsync", 32'(hsync), 32'(e_hs ^ pol[0]));
        chk(vsync == (e_vs ^ pol[1]), "R3 R10", "vsync", 32'(vsync), 32'(e_vs ^ pol[1]));
        chk(de == (e_de ^ pol[2]), "R5 R10", "de", 32'(de), 32'(e_de ^ pol[2]));
        chk(pix_ready == e_rdy, "R7", "pix_ready", 32'(pix_ready), 32'(e_rdy));
        chk(pix_out == e_pix, "R6", "pix_out", 32'(pix_out), 32'(e_pix));
        // R4 counter model
        wrapm = en && (mf == vper - 1);
        if (!en || wrapm) begin
            mf = 0; mh = 0;
        end else begin
            mf = mf + 1;
            mh = (mh == hper - 1) ? 0 : mh + 1;
        end
        if (!en || wrapm) for (int i = 0; i < 16; i++) sh[i] = st[i];
        if (w) st[a] = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 32'h0);
    endtask

    // R11 register addresses 1..10 written in order
    task automatic write_cfg();
        for (int i = 1; i <= 10; i++) tick(1, i, cw[i]);
    endtask

    task automatic rand_cfg();
        int hp, hbp, ha, pad, hfp, hper, vp, vbp, va, vpad, vfp, lines, skew, hst;
        hp = 1 + $urandom % 3; hbp = $urandom % 3; ha = 2 + $urandom % 8;
        pad = $urandom % 2; hfp = 1 + $urandom % 3;
        hper = hp + hbp + ha + pad + hfp;
        vp = 1 + $urandom % 2; vbp = $urandom % 2; va = 1 + $urandom % 4;
        vpad = $urandom % 2; vfp = 1 + $urandom % 2;
        lines = vp + vbp + va + vpad + vfp;
        skew = $urandom % 3;
        hst = hp + hbp;
        cw[1]  = {16'(hper), 16'(hp)};
        cw[2]  = 32'(lines * hper);
        cw[3]  = 32'(vp * hper);
        cw[4]  = {16'(hper - hfp - 1), 16'(hst)};
        cw[5]  = 32'((vp + vbp) * hper + skew);
        cw[6]  = 32'(lines * hper - vfp * hper + skew - 1);
        cw[7]  = {1'($urandom % 2), 15'(hst + ha - 1), 16'(hst + $urandom % 2)};
        cw[8]  = {8'h0, 24'($urandom)};
        cw[9]  = 32'(skew);
        cw[10] = 32'($urandom % 8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) begin st[i] = '0; sh[i] = '0; end
        mh = 0; mf = 0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; pix_in = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk({hsync, vsync, de, pix_ready} == 4'b0, "R1", "sync outputs in reset",
            32'({hsync, vsync, de, pix_ready}), 32'h0);
        chk(pix_out == 24'h0, "R1", "pix_out in reset", 32'(pix_out), 32'h0);
        @(negedge clk); rst_n = 1'b1;
        idle(3);

        // directed geometry: 13-clock lines, 6 lines, skew 0
        cw[1] = {16'd13, 16'd2}; cw[2] = 32'd78; cw[3] = 32'd13;
        cw[4] = {16'd10, 16'd4}; cw[5] = 32'd26; cw[6] = 32'd64;
        cw[7] = 32'h8000_0000 | (32'd9 << 16) | 32'd5;
        cw[8] = 32'h003c5a96; cw[9] = 32'd0; cw[10] = 32'd0;
        write_cfg();
        tick(1, 0, 32'd1);
        // R4 first enabled cycle starts at frame position 0
        tick(0, 0, 32'h0);
        chk(vsync == 1'b1 && hsync == 1'b1, "R4", "syncs at frame start",
            32'({hsync, vsync}), 32'h3);
        idle(100);
        // R9 mid-frame write of inversion must not change the current frame
        tick(1, 10, 32'h7);
        tick(0, 0, 32'h0);
        chk(de == e_de, "R9", "de polarity held mid-frame", 32'(de), 32'(e_de));
        chk(hsync == e_hs, "R9", "hsync polarity held mid-frame", 32'(hsync), 32'(e_hs));
        // R9 line length write mid-frame, model keeps the old geometry
        tick(1, 1, {16'd20, 16'd3});
        idle(120);
        tick(1, 1, cw[1]);
        idle(160);
        // R11 writes to unused addresses have no effect
        tick(1, 12, 32'hffff_ffff);
        tick(1, 15, 32'hffff_ffff);
        idle(80);
        // R8 disable: outputs rest at inverted inactive levels
        tick(1, 0, 32'd0);
        idle(3);
        tick(0, 0, 32'h0);
        chk({hsync, vsync, de} == 3'b111, "R8", "idle levels with inversion",
            32'({hsync, vsync, de}), 32'h7);
        chk(pix_ready == 1'b0 && pix_out == 24'h0, "R8", "no pixel while idle",
            32'({pix_ready, pix_out}), 32'h0);
        idle(10);

        // random geometries, each run for over two frames with a mid-frame write
        for (int k = 0; k < 12; k++) begin
            tick(1, 0, 32'd0);
            rand_cfg();
            write_cfg();
            tick(1, 0, 32'd1);
            idle(int'(cw[2]) + int'($urandom % 40));
            tick(1, 8, 32'($urandom) & 32'h00ff_ffff);
            tick(1, 10, 32'($urandom % 8));
            idle(int'(cw[2]) * 2);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule